// File: doc/BRIEF.md
# Subcode-Q Serial Readout Port

This block sits between the subcode decoding path of a disc playback controller and a host controller. Upstream logic presents each decoded subcode-Q record as a parallel word, together with a one-cycle strobe that marks a record whose CRC check passed and the record's 4-bit address field. The port keeps at most one qualifying record and raises a ready flag to tell the host that a fresh record is waiting.

The host reads the record bit by bit. It toggles a serial clock and samples a serial data line, and it picks least- or most-significant-bit-first order with a level input. The first rising serial clock edge locks the stored record, so a later capture cannot corrupt a read that is under way. When the read is finished, the host pulses a grant input. The pulse unlocks capture, drops the ready flag and rewinds the bit position. If the host does not read in time, the ready flag drops by itself after a fixed window. The data line is only driven while the active-low chip select is asserted.

All host inputs are asynchronous to the system clock. They pass through a parameterised synchroniser before any edge is detected.

Top module: `subq_readout_port`

## Requirements
- R1: On the clock edge that samples `q_crc_pass_i` high with `q_addr_i` equal to 1, and the port not locked, the record is stored, the bit position goes to 0, and `host_ready_o` is high from that edge onward.
- R2: A strobe with an address field other than 1 is ignored while `addr_free_i` is low. It is accepted like R1 when `addr_free_i` is high. A cycle with `q_crc_pass_i` low never stores.
- R3: Without a grant or a new capture, `host_ready_o` stays high for exactly `TIMEOUT_CYC` clock cycles and then falls. A new capture restarts the window.
- R4: The first synchronised rising edge of `host_sclk_i` while chip select is low locks the port. Strobes offered while locked are dropped: the stored record and the ready window are unchanged.
- R5: A synchronised rising edge of `host_grant_i` unlocks the port, forces `host_ready_o` low and returns the bit position to 0. A strobe in that same cycle is dropped.
- R6: Each synchronised falling edge of `host_sclk_i` while chip select is low advances the bit position k by one. With `host_msb_first_i` low the line shows record bit k. With it high the line shows bit `REC_W-1-k`.
- R7: While `host_cs_n_i` is high, `host_sdo_en_o` is low and `host_sdo_o` is high-impedance. Serial clock edges seen while the synchronised chip select is high move neither the lock nor the bit position.
- R8: The bit position saturates at `REC_W-1`. Further falling edges keep presenting the last bit.
- R9: A host input change made after clock edge 0 takes effect through `SYNC_STAGES` flops. A serial clock edge moves the data line after edge `SYNC_STAGES+1`. A bit-order change moves it after edge `SYNC_STAGES`.
- R10: After reset, `host_ready_o` is low, the record is all zeros, the bit position is 0 and the port is unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_rec_i | input | REC_W | Parallel subcode-Q record |
| q_crc_pass_i | input | 1 | One-cycle strobe: record present and CRC good |
| q_addr_i | input | ADDR_W | Address field of the offered record |
| addr_free_i | input | 1 | Level: accept any address field |
| host_sclk_i | input | 1 | Host serial read clock (asynchronous) |
| host_grant_i | input | 1 | Host update-grant pulse (asynchronous) |
| host_msb_first_i | input | 1 | Bit order: 0 LSB first, 1 MSB first |
| host_cs_n_i | input | 1 | Active-low chip select |
| host_sdo_o | output | 1 | Serial data, high-impedance when deselected |
| host_sdo_en_o | output | 1 | High while `host_sdo_o` is driven |
| host_ready_o | output | 1 | Record-ready flag |

## Verification
The bench builds the port with `TIMEOUT_CYC` set to 60 and `SYNC_STAGES` at 2, while keeping the full 80-bit record. The short window lets the bench watch the flag expire both with no read and in the middle of a long read. It also lets the bench check the restart of the window on recapture, all within a few thousand cycles. Two synchroniser stages keep the R9 latency visible in every serial clock edge, and the full record width lets the bench drive more than 80 falling edges to reach the saturation of R8.

// File: rtl/sqr_pkg.sv
package sqr_pkg;

   // Host-side pins, grouped so they can share one synchroniser.
   typedef struct packed {
      logic sclk;
      logic grant;
      logic msb_first;
      logic cs_n;
   } host_pins_t;

   localparam int unsigned HOST_W = $bits(host_pins_t);

   // Reset image of the synchronised host pins: deselected, idle.
   localparam host_pins_t HOST_IDLE = '{sclk: 1'b0, grant: 1'b0, msb_first: 1'b0, cs_n: 1'b1};

endpackage

// File: rtl/sqr_sync.sv
module sqr_sync #(
   parameter int unsigned W       = 1,
   parameter int unsigned STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (W < 1) begin : g_bad_w
      $error("sqr_sync: W must be at least 1");
   end
   if (STAGES > 4) begin : g_bad_stages
      $error("sqr_sync: STAGES above 4 is not supported");
   end

   if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
   end else begin : g_chain
      logic [W-1:0] stage_q [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
         end else begin
            stage_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
         end
      end
      assign q_o = stage_q[STAGES-1];
   end

endmodule

// File: rtl/sqr_timeout.sv
module sqr_timeout #(
   parameter int unsigned CYCLES = 189660
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic kill_i,
   output logic live_o
);

   localparam int unsigned CW   = (CYCLES < 2) ? 1 : $clog2(CYCLES);
   localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

   if (CYCLES < 2) begin : g_bad_cycles
      $error("sqr_timeout: CYCLES must be at least 2");
   end

   logic [CW-1:0] cnt_q;
   logic          live_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         live_q <= 1'b0;
      end else if (kill_i) begin
         cnt_q  <= '0;
         live_q <= 1'b0;
      end else if (start_i) begin
         cnt_q  <= '0;
         live_q <= 1'b1;
      end else if (live_q) begin
         if (cnt_q == LAST) begin
            live_q <= 1'b0;
            cnt_q  <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign live_o = live_q;

   // R3: the window closes on its last count unless restarted or killed.
   assert_window_closes_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && cnt_q == LAST && !start_i && !kill_i) |=> !live_o);

   // R3: the count never runs past the window.
   assert_count_bounded_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      live_q |-> (cnt_q <= LAST));

endmodule

// File: rtl/sqr_bitsel.sv
module sqr_bitsel #(
   parameter int unsigned W  = 80,
   parameter int unsigned IW = 7
) (
   input  logic [W-1:0]  rec_i,
   input  logic [IW-1:0] pos_i,
   input  logic          msb_first_i,
   output logic          bit_o
);

   logic [W-1:0] rev;

   for (genvar g = 0; g < W; g++) begin : g_rev
      assign rev[g] = rec_i[W-1-g];
   end

   always_comb begin
      bit_o = 1'b0;
      for (int k = 0; k < W; k++) begin
         if (pos_i == IW'(k)) bit_o = msb_first_i ? rev[k] : rec_i[k];
      end
   end

endmodule

// File: rtl/subq_readout_port.sv
module subq_readout_port #(
   parameter int unsigned REC_W       = 80,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned MATCH_ADDR  = 1,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned CLK_KHZ     = 16934,
   parameter int unsigned WINDOW_US   = 11200,
   parameter int unsigned TIMEOUT_CYC = CLK_KHZ * WINDOW_US / 1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REC_W-1:0]  q_rec_i,
   input  logic              q_crc_pass_i,
   input  logic [ADDR_W-1:0] q_addr_i,
   input  logic              addr_free_i,
   input  logic              host_sclk_i,
   input  logic              host_grant_i,
   input  logic              host_msb_first_i,
   input  logic              host_cs_n_i,
   output logic              host_sdo_o,
   output logic              host_sdo_en_o,
   output logic              host_ready_o
);
   import sqr_pkg::*;

   localparam int unsigned IW   = (REC_W < 2) ? 1 : $clog2(REC_W);
   localparam logic [IW-1:0] LAST_POS = IW'(REC_W - 1);
   localparam logic [ADDR_W-1:0] HIT  = ADDR_W'(MATCH_ADDR);

   if (REC_W < 2) begin : g_bad_rec
      $error("subq_readout_port: REC_W must be at least 2");
   end
   if (MATCH_ADDR >= (1 << ADDR_W)) begin : g_bad_match
      $error("subq_readout_port: MATCH_ADDR does not fit ADDR_W");
   end

   // ---------------- host pin synchronisation ----------------
   host_pins_t pins_raw, pins_s;
   logic       sclk_prev_q, grant_prev_q;

   assign pins_raw = '{sclk: host_sclk_i, grant: host_grant_i,
                       msb_first: host_msb_first_i, cs_n: host_cs_n_i};

   sqr_sync #(.W(HOST_W), .STAGES(SYNC_STAGES), .RST_VAL(HOST_IDLE)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (pins_raw),
      .q_o  (pins_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_prev_q  <= 1'b0;
         grant_prev_q <= 1'b0;
      end else begin
         sclk_prev_q  <= pins_s.sclk;
         grant_prev_q <= pins_s.grant;
      end
   end

   logic sel_s, sclk_rise, sclk_fall, grant_rise;
   assign sel_s      = !pins_s.cs_n;
   assign sclk_rise  = sel_s &&  pins_s.sclk && !sclk_prev_q;
   assign sclk_fall  = sel_s && !pins_s.sclk &&  sclk_prev_q;
   assign grant_rise = pins_s.grant && !grant_prev_q;

   // ---------------- capture gating ----------------
   logic frozen_q, addr_ok, take;
   assign addr_ok = addr_free_i || (q_addr_i == HIT);
   assign take    = q_crc_pass_i && addr_ok && !frozen_q && !grant_rise;

   logic [REC_W-1:0] rec_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rec_q <= '0;
      else if (take)  rec_q <= q_rec_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          frozen_q <= 1'b0;
      else if (grant_rise) frozen_q <= 1'b0;
      else if (sclk_rise)  frozen_q <= 1'b1;
   end

   // ---------------- bit position ----------------
   logic [IW-1:0] pos_q;
   logic          rewind;
   assign rewind = grant_rise || take;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             pos_q <= '0;
      else if (rewind)                        pos_q <= '0;
      else if (sclk_fall && pos_q != LAST_POS) pos_q <= pos_q + 1'b1;
   end

   // ---------------- ready window ----------------
   sqr_timeout #(.CYCLES(TIMEOUT_CYC)) u_window (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_i(take),
      .kill_i (grant_rise),
      .live_o (host_ready_o)
   );

   // ---------------- serial output ----------------
   logic cur_bit;
   sqr_bitsel #(.W(REC_W), .IW(IW)) u_bitsel (
      .rec_i      (rec_q),
      .pos_i      (pos_q),
      .msb_first_i(pins_s.msb_first),
      .bit_o      (cur_bit)
   );

   assign host_sdo_en_o = !host_cs_n_i;
   assign host_sdo_o    = host_cs_n_i ? 1'bz : cur_bit;

   // ---------------- assertions ----------------
   // R1 / R2: the flag only rises after a qualifying strobe.
   assert_ready_needs_qualified_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(host_ready_o) |-> $past(q_crc_pass_i && (addr_free_i || q_addr_i == HIT)));

   // R4: a locked port keeps its record.
   assert_locked_record_holds_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (frozen_q && !grant_rise) |=> $stable(rec_q));

   // R5: a grant drops the flag and the lock.
   assert_grant_clears_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      grant_rise |=> (!host_ready_o && !frozen_q && pos_q == '0));

   // R8: the last bit position is sticky until rewound.
   assert_pos_saturates_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (pos_q == LAST_POS && !rewind) |=> pos_q == LAST_POS);

   // R7: a deselected port never moves its bit position.
   assert_deselect_no_shift_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (pins_s.cs_n && !rewind) |=> $stable(pos_q));

endmodule

// File: tb/subq_readout_port_tb_top.sv
module subq_readout_port_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int RW   = 80;
   localparam int TO   = 60;
   localparam int SYNC = 2;
   localparam int HALF = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [RW-1:0] q_rec = '0;
   logic q_crc = 1'b0;
   logic [3:0] q_addr = '0;
   logic afree = 1'b0;
   logic sclk = 1'b0, grant = 1'b0, msbf = 1'b0, cs_n = 1'b1;
   logic sdo, sdo_en, ready;

   always #(CLK_PERIOD/2) clk = ~clk;

   subq_readout_port #(.REC_W(RW), .SYNC_STAGES(SYNC), .TIMEOUT_CYC(TO)) dut_i (
      .clk(clk), .rst_n(rst_n), .q_rec_i(q_rec), .q_crc_pass_i(q_crc), .q_addr_i(q_addr),
      .addr_free_i(afree), .host_sclk_i(sclk), .host_grant_i(grant),
      .host_msb_first_i(msbf), .host_cs_n_i(cs_n),
      .host_sdo_o(sdo), .host_sdo_en_o(sdo_en), .host_ready_o(ready));

   int checks = 0, fails = 0;
   string tag = "R10";
   bit done = 1'b0;

   task automatic chk(string req, logic act, logic exp, string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [RW-1:0] m_rec = '0;
   bit m_ready = 0, m_lock = 0;
   int m_pos = 0, m_cnt = 0;
   bit sp[SYNC], gp[SYNC], op[SYNC], cp[SYNC];
   bit s_prev = 0, g_prev = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_rec = '0; m_ready = 0; m_lock = 0; m_pos = 0; m_cnt = 0;
         s_prev = 0; g_prev = 0;
         for (int i = 0; i < SYNC; i++) begin sp[i] = 0; gp[i] = 0; op[i] = 0; cp[i] = 1; end
      end else begin
         bit sel, rise, fall, grise, take;
         sel   = !cp[SYNC-1];
         rise  = sel && sp[SYNC-1] && !s_prev;
         fall  = sel && !sp[SYNC-1] && s_prev;
         grise = gp[SYNC-1] && !g_prev;
         take  = q_crc && (afree || q_addr == 4'd1) && !m_lock && !grise;
         if (grise) begin
            m_ready = 0; m_lock = 0; m_pos = 0; m_cnt = 0;
         end else begin
            if (take) begin
               m_rec = q_rec; m_ready = 1; m_cnt = 0; m_pos = 0;
            end else if (m_ready) begin
               if (m_cnt == TO-1) m_ready = 0; else m_cnt++;
            end
            if (rise) m_lock = 1;
            if (!take && fall && m_pos < RW-1) m_pos++;
         end
         s_prev = sp[SYNC-1]; g_prev = gp[SYNC-1];
         for (int i = SYNC-1; i > 0; i--) begin
            sp[i] = sp[i-1]; gp[i] = gp[i-1]; op[i] = op[i-1]; cp[i] = cp[i-1];
         end
         sp[0] = sclk; gp[0] = grant; op[0] = msbf; cp[0] = cs_n;
      end
   end

   // Compare every cycle, away from the active edge.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(tag, ready, m_ready, "ready flag");
         chk(tag, sdo_en, !cs_n, "drive enable");
         if (!cs_n)
            chk(tag, sdo, op[SYNC-1] ? m_rec[RW-1-m_pos] : m_rec[m_pos], "serial bit");
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic tick(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic offer(logic [RW-1:0] v, logic [3:0] a, logic crc);
      q_rec = v; q_addr = a; q_crc = crc;
      tick(1);
      q_crc = 1'b0;
   endtask

   task automatic clk_pulse();
      sclk = 1'b1; tick(HALF);
      sclk = 1'b0; tick(HALF);
   endtask

   task automatic do_grant();
      grant = 1'b1; tick(HALF);
      grant = 1'b0; tick(HALF);
   endtask

   task automatic report();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         report();
      end
   end

   localparam logic [RW-1:0] REC_A = 80'hA5C3_0F1E_2D3C_4B5A_6978;
   localparam logic [RW-1:0] REC_B = 80'h8001_1234_5678_9ABC_DEF1;
   localparam logic [RW-1:0] REC_C = 80'h7E5D_3C1B_0A99_8877_6655;
   localparam logic [RW-1:0] REC_D = 80'h0F0F_F0F0_1111_EEEE_C3C3;

   initial begin
      tick(3);
      // R10: reset state visible at the ports.
      chk("R10", ready, 1'b0, "ready during reset");
      rst_n = 1'b1;
      cs_n = 1'b0;
      tick(4);
      chk("R10", ready, 1'b0, "ready after reset");
      chk("R10", sdo, 1'b0, "record cleared after reset");

      // R1: qualifying record, read ten bits LSB first (R6, R9).
      tag = "R1";
      offer(REC_A, 4'd1, 1'b1);
      chk("R1", ready, 1'b1, "ready after capture");
      chk("R1", sdo, REC_A[0], "first bit after capture");
      tag = "R9";
      for (int i = 0; i < 10; i++) clk_pulse();
      tag = "R6";
      chk("R6", sdo, REC_A[10], "bit 10 LSB first");
      msbf = 1'b1; tick(SYNC);
      chk("R9", sdo, REC_A[RW-1-10], "order switch after sync latency");
      msbf = 1'b0; tick(SYNC);

      // R5: grant releases and clears the flag.
      tag = "R5";
      do_grant();
      chk("R5", ready, 1'b0, "ready after grant");
      chk("R5", sdo, REC_A[0], "position rewound after grant");

      // R2: address filter and CRC gating.
      tag = "R2";
      offer(REC_B, 4'd2, 1'b1);
      chk("R2", ready, 1'b0, "wrong address ignored");
      chk("R2", sdo, REC_A[0], "record kept after wrong address");
      offer(REC_B, 4'd1, 1'b0);
      chk("R2", ready, 1'b0, "no crc pass ignored");
      afree = 1'b1;
      offer(REC_D, 4'd5, 1'b1);
      chk("R2", ready, 1'b1, "address free accepts");
      chk("R2", sdo, REC_D[0], "address free record stored");
      afree = 1'b0;

      // R3: window expiry and restart.
      tag = "R3";
      tick(TO - 10);
      offer(REC_B, 4'd1, 1'b1);
      tick(TO - 2);
      chk("R3", ready, 1'b1, "window restarted by recapture");
      tick(2);
      chk("R3", ready, 1'b0, "window expired");

      // R4 / R6 / R8: locked MSB-first read of the whole record and beyond.
      tag = "R4";
      msbf = 1'b1;
      offer(REC_C, 4'd1, 1'b1);
      tick(SYNC);
      clk_pulse();
      offer(REC_A, 4'd1, 1'b1);
      chk("R4", sdo, REC_C[RW-2], "capture dropped while locked");
      tag = "R8";
      for (int i = 0; i < RW + 3; i++) clk_pulse();
      chk("R8", sdo, REC_C[0], "last bit held after overrun");
      chk("R3", ready, 1'b0, "window expired during long read");

      // R7: deselected port.
      tag = "R7";
      cs_n = 1'b1; tick(1);
      chk("R7", sdo_en, 1'b0, "drive released when deselected");
      do_grant();
      offer(REC_B, 4'd1, 1'b1);
      for (int i = 0; i < 5; i++) clk_pulse();
      cs_n = 1'b0; tick(SYNC + 1);
      chk("R7", sdo, REC_B[RW-1], "clock ignored while deselected");
      offer(REC_C, 4'd1, 1'b1);
      chk("R7", sdo, REC_C[RW-1], "not locked by deselected clocks");

      // R5: grant in the same cycle as a strobe drops the strobe.
      tag = "R5";
      clk_pulse();
      grant = 1'b1; tick(SYNC);
      offer(REC_D, 4'd1, 1'b1);
      chk("R5", ready, 1'b0, "strobe in grant cycle dropped");
      grant = 1'b0; tick(HALF);
      offer(REC_D, 4'd1, 1'b1);
      chk("R5", sdo, REC_D[RW-1], "capture works after grant");
      tick(10);
      report();
   end

endmodule